// File: doc/BRIEF.md
# Pulse Period and High-Time Meter

This block measures a pulse-width-modulated signal from single-cycle edge strobes that an upstream capture stage has already synchronised and qualified. A W-bit counter runs freely for as long as the block is out of reset. It is never reloaded and never aligned to the measured signal. Each strobe takes a snapshot of the counter. The block keeps the snapshot of the last rising edge and the snapshot of the first falling edge after it. When the next rising edge arrives, it reports the high time and the period as wrap-safe differences modulo 2^W.

Jitter can be reduced with two averagers. One follows rising strobes and the other follows falling strobes, and each works on its own. An averager sums n like-polarity intervals back to back, where n = 2^AVG_LOG2, and reports the floor of the sum divided by n. The division is a right shift. Every result may be off by one count, because an edge is seen only at the clock edge. Turning the results into a duty ratio or into physical time is left to the consumer.

Top module: `pwm_meter`

## Requirements
- R1: While reset is held and after it is released, before any strobe, every valid, error and overflow output is 0 and every result output is 0.
- R2: The first rising strobe after reset only records its time and produces no result. Falling strobes seen before that first rising strobe are ignored.
- R3: On every later rising strobe, meas_valid_o pulses for one cycle, on the cycle after the strobe is sampled. period_o equals the number of clock cycles between this rising strobe and the previous one, modulo 2^W.
- R4: With that result, high_time_o equals the number of cycles from the previous rising strobe to the first falling strobe after it, modulo 2^W.
- R5: Results stay correct when the free-running counter wraps between two strobes, provided the interval is shorter than 2^W cycles.
- R6: If no falling strobe came between two rising strobes, the result carries meas_err_o = 1 and high_time_o = 0. period_o is still reported.
- R7: Only the first falling strobe after a rising strobe is used. Later falling strobes, and a falling strobe in the same cycle as a rising strobe, do not change the measured high time.
- R8: If the interval between rising strobes is 2^W cycles or longer, meas_ovf_o = 1 with the result, and period_o holds the interval modulo 2^W. Otherwise meas_ovf_o = 0.
- R9: The rising averager is primed by the first rising strobe after reset. After that, every n further rising strobes produce one avg_rise_valid_o pulse, with avg_rise_o = floor(sum of those n periods / n). Windows follow one another, and the strobe that ends one window starts the next.
- R10: The falling averager does the same on falling strobes, independently of the rising path. On either averager, the overflow output is 1 when any interval in that window reached 2^W cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rise_i | input | 1 | Qualified rising-edge strobe, one cycle wide |
| fall_i | input | 1 | Qualified falling-edge strobe, one cycle wide |
| high_time_o | output | W | High time of the last completed cycle, in clocks |
| period_o | output | W | Period of the last completed cycle, in clocks |
| meas_valid_o | output | 1 | One-cycle pulse when a new result is available |
| meas_err_o | output | 1 | No falling edge was seen in the reported cycle |
| meas_ovf_o | output | 1 | The reported period reached 2^W clocks |
| avg_rise_o | output | W | Averaged rising-to-rising period |
| avg_rise_valid_o | output | 1 | Pulse with a new rising average |
| avg_rise_ovf_o | output | 1 | A rising interval in the window reached 2^W |
| avg_fall_o | output | W | Averaged falling-to-falling period |
| avg_fall_valid_o | output | 1 | Pulse with a new falling average |
| avg_fall_ovf_o | output | 1 | A falling interval in the window reached 2^W |

## Verification
A wrong stored timestamp shows up in period_o or high_time_o with the very next rising-strobe result, one cycle after that strobe is sampled. A stuck falling-seen flag shows up as a spurious or missing meas_err_o on that same result. A faulty wrap watch goes unseen until an interval reaches 2^W, so the bench places periods of 2^W-1, 2^W and more than 2^W to expose it. A corrupted averager sum or window count shows up only at the end of a window, up to n strobes later. The bench therefore counts window outputs as well as their values.

// File: rtl/pwm_meter_pkg.sv
package pwm_meter_pkg;

    typedef enum logic [0:0] {
        STRM_RISE = 1'b0,
        STRM_FALL = 1'b1
    } strm_e;

    localparam int unsigned NUM_STRM = 2;

    function automatic int unsigned win_cnt_width(input int unsigned log2n);
        return (log2n > 0) ? log2n : 1;
    endfunction

endpackage

// File: rtl/pm_free_timer.sv
module pm_free_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;

    // R5
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s_q.cnt - $past(s_q.cnt)) == W'(1));

endmodule

// File: rtl/pm_edge_meas.sv
module pm_edge_meas #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic         rise_i,
    input  logic         fall_i,
    output logic [W-1:0] high_o,
    output logic [W-1:0] period_o,
    output logic         valid_o,
    output logic         err_o,
    output logic         ovf_o
);

    typedef struct packed {
        logic         primed;
        logic [W-1:0] rise_ts;
        logic [W-1:0] fall_ts;
        logic         fall_seen;
        logic         lap;
        logic         out_valid;
        logic         out_err;
        logic         out_ovf;
        logic [W-1:0] out_high;
        logic [W-1:0] out_period;
    } meas_s;

    meas_s s_d, s_q;
    logic  hit;
    logic  lap_now;

    always_comb begin
        // the counter returning to the stored rising time means a full lap elapsed
        hit     = s_q.primed && (cnt_i == s_q.rise_ts);
        lap_now = s_q.lap | hit;
        s_d           = s_q;
        s_d.out_valid = 1'b0;
        s_d.out_err   = 1'b0;
        s_d.out_ovf   = 1'b0;
        if (rise_i) begin
            if (s_q.primed) begin
                s_d.out_valid  = 1'b1;
                s_d.out_period = cnt_i - s_q.rise_ts;
                s_d.out_ovf    = lap_now;
                if (s_q.fall_seen) begin
                    s_d.out_high = s_q.fall_ts - s_q.rise_ts;
                end else begin
                    s_d.out_high = '0;
                    s_d.out_err  = 1'b1;
                end
            end
            s_d.primed    = 1'b1;
            s_d.rise_ts   = cnt_i;
            s_d.fall_seen = 1'b0;
            s_d.lap       = 1'b0;
        end else begin
            s_d.lap = lap_now;
            if (fall_i && s_q.primed && !s_q.fall_seen) begin
                s_d.fall_ts   = cnt_i;
                s_d.fall_seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign high_o   = s_q.out_high;
    assign period_o = s_q.out_period;
    assign valid_o  = s_q.out_valid;
    assign err_o    = s_q.out_err;
    assign ovf_o    = s_q.out_ovf;

    // R3
    meas_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(rise_i));

    // R2
    unprimed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.primed |=> !valid_o);

    // R6
    err_zero_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (valid_o && high_o == '0));

    // R4
    high_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !err_o && !ovf_o) |-> (high_o != '0 && high_o < period_o));

endmodule

// File: rtl/pm_edge_avg.sv
module pm_edge_avg #(
    parameter int unsigned W        = 16,
    parameter int unsigned AVG_LOG2 = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic         edge_i,
    output logic [W-1:0] avg_o,
    output logic         valid_o,
    output logic         ovf_o
);

    import pwm_meter_pkg::*;

    localparam int unsigned ACC_W = W + AVG_LOG2;
    localparam int unsigned CW    = win_cnt_width(AVG_LOG2);
    localparam int unsigned N     = 1 << AVG_LOG2;

    typedef struct packed {
        logic             primed;
        logic [W-1:0]     last_ts;
        logic [ACC_W-1:0] acc;
        logic [CW-1:0]    cnt;
        logic             lap;
        logic             out_valid;
        logic             out_ovf;
        logic [W-1:0]     out_avg;
    } avg_s;

    avg_s             s_d, s_q;
    logic             hit;
    logic             lap_now;
    logic [W-1:0]     delta;
    logic [ACC_W-1:0] sum;

    always_comb begin
        hit     = s_q.primed && (cnt_i == s_q.last_ts);
        lap_now = s_q.lap | hit;
        delta   = cnt_i - s_q.last_ts;
        sum     = s_q.acc + ACC_W'(delta);
        s_d           = s_q;
        s_d.out_valid = 1'b0;
        s_d.out_ovf   = 1'b0;
        s_d.lap       = lap_now;
        if (edge_i) begin
            s_d.last_ts = cnt_i;
            if (!s_q.primed) begin
                s_d.primed = 1'b1;
                s_d.acc    = '0;
                s_d.cnt    = '0;
                s_d.lap    = 1'b0;
            end else if (s_q.cnt == CW'(N - 1)) begin
                s_d.out_valid = 1'b1;
                s_d.out_avg   = sum[ACC_W-1:AVG_LOG2];
                s_d.out_ovf   = lap_now;
                s_d.acc       = '0;
                s_d.cnt       = '0;
                s_d.lap       = 1'b0;
            end else begin
                s_d.acc = sum;
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign avg_o   = s_q.out_avg;
    assign valid_o = s_q.out_valid;
    assign ovf_o   = s_q.out_ovf;

    // R9
    avg_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(edge_i));

    // R9
    window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (s_q.cnt == '0 && s_q.acc == '0));

    // R10
    ovf_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> valid_o);

endmodule

// File: rtl/pwm_meter.sv
module pwm_meter #(
    parameter int unsigned W        = 16,
    parameter int unsigned AVG_LOG2 = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_i,
    input  logic         fall_i,
    output logic [W-1:0] high_time_o,
    output logic [W-1:0] period_o,
    output logic         meas_valid_o,
    output logic         meas_err_o,
    output logic         meas_ovf_o,
    output logic [W-1:0] avg_rise_o,
    output logic         avg_rise_valid_o,
    output logic         avg_rise_ovf_o,
    output logic [W-1:0] avg_fall_o,
    output logic         avg_fall_valid_o,
    output logic         avg_fall_ovf_o
);

    import pwm_meter_pkg::*;

    logic [W-1:0] cnt;
    logic [W-1:0] avg_val   [NUM_STRM];
    logic         avg_valid [NUM_STRM];
    logic         avg_ovf   [NUM_STRM];

    pm_free_timer #(.W(W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt)
    );

    pm_edge_meas #(.W(W)) i_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_i    (cnt),
        .rise_i   (rise_i),
        .fall_i   (fall_i),
        .high_o   (high_time_o),
        .period_o (period_o),
        .valid_o  (meas_valid_o),
        .err_o    (meas_err_o),
        .ovf_o    (meas_ovf_o)
    );

    for (genvar g = 0; g < NUM_STRM; g++) begin : g_avg
        localparam strm_e KIND = strm_e'(g);
        logic strobe;
        assign strobe = (KIND == STRM_RISE) ? rise_i : fall_i;

        pm_edge_avg #(.W(W), .AVG_LOG2(AVG_LOG2)) i_avg (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_i   (cnt),
            .edge_i  (strobe),
            .avg_o   (avg_val[g]),
            .valid_o (avg_valid[g]),
            .ovf_o   (avg_ovf[g])
        );
    end

    assign avg_rise_o       = avg_val[STRM_RISE];
    assign avg_rise_valid_o = avg_valid[STRM_RISE];
    assign avg_rise_ovf_o   = avg_ovf[STRM_RISE];
    assign avg_fall_o       = avg_val[STRM_FALL];
    assign avg_fall_valid_o = avg_valid[STRM_FALL];
    assign avg_fall_ovf_o   = avg_ovf[STRM_FALL];

endmodule

// File: tb/test_pwm_meter.sv
`timescale 1ns/1ps
module test_pwm_meter;

    localparam int W   = 10;
    localparam int L   = 2;
    localparam int N   = 1 << L;
    localparam int MOD = 1 << W;

    logic clk = 1'b0, rst_n = 1'b0, rise_i = 1'b0, fall_i = 1'b0;
    logic [W-1:0] high_time_o, period_o, avg_rise_o, avg_fall_o;
    logic meas_valid_o, meas_err_o, meas_ovf_o;
    logic avg_rise_valid_o, avg_rise_ovf_o, avg_fall_valid_o, avg_fall_ovf_o;

    always #2 clk = ~clk;

    pwm_meter #(.W(W), .AVG_LOG2(L)) i_pwm_meter (
        .clk(clk), .rst_n(rst_n), .rise_i(rise_i), .fall_i(fall_i),
        .high_time_o(high_time_o), .period_o(period_o),
        .meas_valid_o(meas_valid_o), .meas_err_o(meas_err_o), .meas_ovf_o(meas_ovf_o),
        .avg_rise_o(avg_rise_o), .avg_rise_valid_o(avg_rise_valid_o),
        .avg_rise_ovf_o(avg_rise_ovf_o), .avg_fall_o(avg_fall_o),
        .avg_fall_valid_o(avg_fall_valid_o), .avg_fall_ovf_o(avg_fall_ovf_o)
    );

    typedef struct {int high; int period; bit err; bit ovf; string req;} meas_t;
    typedef struct {int val; bit ovf;} avg_t;

    meas_t mq[$];
    avg_t  arq[$], afq[$];
    meas_t me;
    avg_t  ae;

    int checks = 0, fails = 0, tcount = 0;
    int seen_meas = 0, seen_ar = 0, seen_af = 0, exp_ar = 0, exp_af = 0;
    string cur_req = "R1";

    bit m_primed, m_fseen;
    int m_rise, m_fall;
    bit a_primed[2];
    int a_last[2], a_sum[2], a_cnt[2];
    bit a_ovf[2];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_primed = 0; m_fseen = 0; m_rise = 0; m_fall = 0;
        for (int s = 0; s < 2; s++) begin
            a_primed[s] = 0; a_last[s] = 0; a_sum[s] = 0; a_cnt[s] = 0; a_ovf[s] = 0;
        end
        mq.delete(); arq.delete(); afq.delete();
        seen_meas = 0; seen_ar = 0; seen_af = 0; exp_ar = 0; exp_af = 0;
    endtask

    task automatic avg_edge(input int s, input int t);
        avg_t it;
        int d;
        if (!a_primed[s]) begin
            a_primed[s] = 1; a_last[s] = t; a_sum[s] = 0; a_cnt[s] = 0; a_ovf[s] = 0;
        end else begin
            d = t - a_last[s];
            if (d >= MOD) a_ovf[s] = 1;
            a_sum[s] += d % MOD;
            a_cnt[s]++;
            a_last[s] = t;
            if (a_cnt[s] == N) begin
                it.val = a_sum[s] / N;
                it.ovf = a_ovf[s];
                if (s == 0) begin arq.push_back(it); exp_ar++; end
                else        begin afq.push_back(it); exp_af++; end
                a_sum[s] = 0; a_cnt[s] = 0; a_ovf[s] = 0;
            end
        end
    endtask

    task automatic drive_cycle(input bit r, input bit f);
        meas_t it;
        int d;
        @(negedge clk);
        rise_i = r;
        fall_i = f;
        tcount++;
        if (r) begin
            if (m_primed) begin
                d = tcount - m_rise;
                it.period = d % MOD;
                it.ovf    = (d >= MOD);
                if (m_fseen) begin it.high = (m_fall - m_rise) % MOD; it.err = 0; end
                else         begin it.high = 0; it.err = 1; end
                it.req = cur_req;
                mq.push_back(it);
            end
            m_primed = 1; m_rise = tcount; m_fseen = 0;
        end else if (f && m_primed && !m_fseen) begin
            m_fall = tcount; m_fseen = 1;
        end
        if (r) avg_edge(0, tcount);
        if (f) avg_edge(1, tcount);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive_cycle(1'b0, 1'b0);
    endtask

    task automatic pulse(input int hi, input int lo);
        drive_cycle(1'b1, 1'b0);
        idle(hi - 1);
        drive_cycle(1'b0, 1'b1);
        idle(lo - 1);
    endtask

    task automatic drain(input string req);
        idle(4);
        chk(req, "results still pending", mq.size() + arq.size() + afq.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rise_i = 1'b0; fall_i = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: compares each produced result with the front of its queue
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (meas_valid_o) begin
                seen_meas++;
                if (mq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R3 unexpected result: actual valid expected none");
                end else begin
                    me = mq.pop_front();
                    chk(me.req, "period", int'(period_o), me.period);
                    chk(me.req, "high time", int'(high_time_o), me.high);
                    chk("R6", "error flag", int'(meas_err_o), int'(me.err));
                    chk("R8", "overflow flag", int'(meas_ovf_o), int'(me.ovf));
                end
            end
            if (avg_rise_valid_o) begin
                seen_ar++;
                if (arq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R9 unexpected rising average: actual valid expected none");
                end else begin
                    ae = arq.pop_front();
                    chk("R9", "rising average", int'(avg_rise_o), ae.val);
                    chk("R10", "rising average overflow", int'(avg_rise_ovf_o), int'(ae.ovf));
                end
            end
            if (avg_fall_valid_o) begin
                seen_af++;
                if (afq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R10 unexpected falling average: actual valid expected none");
                end else begin
                    ae = afq.pop_front();
                    chk("R10", "falling average", int'(avg_fall_o), ae.val);
                    chk("R10", "falling average overflow", int'(avg_fall_ovf_o), int'(ae.ovf));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R3 watchdog: actual hung run expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1", "meas_valid_o", int'(meas_valid_o), 0);
        chk("R1", "period_o", int'(period_o), 0);
        chk("R1", "high_time_o", int'(high_time_o), 0);
        chk("R1", "meas_err_o", int'(meas_err_o), 0);
        chk("R1", "meas_ovf_o", int'(meas_ovf_o), 0);
        chk("R1", "avg_rise_o", int'(avg_rise_o), 0);
        chk("R1", "avg_fall_o", int'(avg_fall_o), 0);
        chk("R1", "avg valid", int'(avg_rise_valid_o | avg_fall_valid_o), 0);

        // R2: early fall ignored, first rise only primes
        cur_req = "R2";
        drive_cycle(1'b0, 1'b1);
        idle(3);
        drive_cycle(1'b1, 1'b0);
        idle(6);
        chk("R2", "results after priming rise", seen_meas, 0);
        drive_cycle(1'b0, 1'b1);
        idle(8);

        // R3 / R4: varied high and low times
        cur_req = "R3";
        pulse(7, 13);
        pulse(3, 5);
        pulse(1, 1);
        cur_req = "R4";
        for (int k = 1; k <= 6; k++) pulse(k * 3, 2 * k + 1);
        pulse(20, 4);
        pulse(2, 30);

        // R5: periods that straddle counter wrap
        cur_req = "R5";
        for (int k = 0; k < 3; k++) pulse(400, 500);

        // R6: missing falling edge
        cur_req = "R6";
        drive_cycle(1'b1, 1'b0);
        idle(9);
        drive_cycle(1'b1, 1'b0);
        idle(4);
        pulse(5, 5);

        // R7: extra falls and a fall coinciding with a rise
        cur_req = "R7";
        drive_cycle(1'b1, 1'b0);
        idle(3);
        drive_cycle(1'b0, 1'b1);
        idle(4);
        drive_cycle(1'b0, 1'b1);
        idle(5);
        drive_cycle(1'b1, 1'b1);
        idle(6);
        drive_cycle(1'b0, 1'b1);
        idle(3);

        // R8: periods of 2^W-1, 2^W and beyond
        cur_req = "R8";
        pulse(10, MOD - 11);
        pulse(10, MOD - 10);
        pulse(10, 1490);
        pulse(5, 5);
        drive_cycle(1'b1, 1'b0);
        drain("R8");
        chk("R9", "rising average count", seen_ar, exp_ar);
        chk("R10", "falling average count", seen_af, exp_af);

        // R9: fresh start, averages with remainders
        do_reset();
        cur_req = "R9";
        for (int k = 0; k < 17; k++) pulse(6 + k % 5, 9 + (k * 3) % 7);
        drive_cycle(1'b1, 1'b0);
        drain("R9");
        chk("R9", "rising average count", seen_ar, exp_ar);
        chk("R9", "rising averages produced", int'(exp_ar >= 4), 1);

        // R10: falling stream with a long gap in one window
        cur_req = "R10";
        pulse(4, 6);
        pulse(3, MOD + 80);
        for (int k = 0; k < 9; k++) pulse(2 + k, 5);
        drive_cycle(1'b1, 1'b0);
        drain("R10");
        chk("R10", "falling average count", seen_af, exp_af);
        chk("R10", "falling averages produced", int'(exp_af >= 3), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule